// File: doc/BRIEF.md
# Orderly Suspend Controller

This block halts the transmit and receive engines of a network controller without cutting any transfer short. Software writes 1 to a suspend-request bit. From the next cycle the block withdraws the enables that let the engines start new work, then waits for work already in flight to finish. Only once every engine is quiescent does the request bit read back as 1, so software polls that bit to learn when suspend has been reached. Writing 0 withdraws the request and restores every enable at once. The engines keep their pointers and FIFO contents across the pause.

Two entry procedures are available, and the mode bit is sampled at the moment the request is accepted.

- **Fast mode** waits only for DMA transfers and on-wire packets that have already begun. It may therefore leave data sitting in the FIFOs.
- **Full-drain mode** additionally waits for both FIFOs to empty. During the drain it keeps open only the step that moves each FIFO towards empty:
  - For transmit, starting packets onto the wire.
  - For receive, starting DMA writes to memory.

Every pin is plain control or status; there is no data stream and so no handshake. Lanes are indexed per direction: even lanes (bit 0 by default) are transmit and odd lanes (bit 1) are receive.

Top module: `orderly_halt`

## Requirements
- R1: After reset the block is running: `susp_rd` is 0 and every bit of `may_pkt` and `may_dma` is 1.
- R2: A write of 1 (`req_wr`=1, `req_wdata`=1) while running clears the feeding enables from the cycle after the write: transmit `may_dma` (bit 0) and receive `may_pkt` (bit 1). In fast mode every enable is cleared.
- R3: In fast mode, `susp_rd` becomes 1 at the first clock edge after the request at which all `dma_busy` and `wire_busy` bits are 0, whatever `fifo_empty` shows. It is never 1 in the cycle right after the write edge.
- R4: In full-drain mode, entry also requires every `fifo_empty` bit to be 1. While draining, transmit `may_pkt` and receive `may_dma` equal the inverse of their own lane's `fifo_empty`.
- R5: While `susp_rd` is 1, every bit of `may_pkt` and `may_dma` is 0.
- R6: A write of 0, whether suspended or still draining, returns the block to running in the next cycle: `susp_rd` is 0 and all enables are 1. A request cancelled during draining never shows `susp_rd`=1.
- R7: A write of 1 while draining or suspended has no effect. It neither re-samples the mode nor changes `susp_rd`.
- R8: `fast_mode` is sampled only at the accepted request. Changing it afterwards does not alter the entry condition.
- R9: A write of 0 while running has no effect: all enables stay 1 and `susp_rd` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Write strobe for the suspend-request bit |
| req_wdata | input | 1 | Value written to the suspend-request bit |
| fast_mode | input | 1 | 1 selects fast entry, 0 selects full drain |
| dma_busy | input | NDIR | Per-lane DMA transfer in progress |
| wire_busy | input | NDIR | Per-lane packet on the wire in progress |
| fifo_empty | input | NDIR | Per-lane FIFO empty |
| may_pkt | output | NDIR | Per-lane permission to start a new packet |
| may_dma | output | NDIR | Per-lane permission to start a new DMA transfer |
| susp_rd | output | 1 | Read-back of the suspend-request bit; 1 only once suspended |

## Verification
A wrong state or a wrongly latched mode shows at the ports within one clock.

- If the block has reached suspend too early, `susp_rd` rises in a cycle that directly follows busy inputs, or while a FIFO is still non-empty in full-drain mode.
- If the block is stuck in drain, `susp_rd` stays low one edge after all quiescence conditions hold.
- If a request is lost, an enable is still high the cycle after the write.
- A stale mode shows as a drain enable that fails to follow `fifo_empty`, or as an early or late entry after `fast_mode` has been toggled mid-drain.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SUSP  = 2'd2
  } halt_st_e;

  // Even lanes carry transmit traffic, odd lanes receive traffic.
  function automatic bit lane_is_rx(input int idx);
    return (idx % 2) == 1;
  endfunction
endpackage

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
#(
  parameter int NDIR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic            req_wdata,
  input  logic            fast_mode,
  input  logic [NDIR-1:0] lane_quiet,
  output logic            run,
  output logic            drain_full,
  output logic            fast_lat,
  output logic            susp
);
  halt_st_e st_q;
  logic     fast_q;
  logic     set_req;
  logic     clr_req;

  assign set_req = req_wr && req_wdata;
  assign clr_req = req_wr && !req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      fast_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (set_req) begin
            st_q   <= ST_DRAIN;
            fast_q <= fast_mode;   // mode sampled only here
          end
        end
        ST_DRAIN: begin
          if (clr_req)          st_q <= ST_RUN;
          else if (&lane_quiet) st_q <= ST_SUSP;
        end
        ST_SUSP: begin
          if (clr_req) st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign run        = (st_q == ST_RUN);
  assign susp       = (st_q == ST_SUSP);
  assign drain_full = (st_q == ST_DRAIN) && !fast_q;
  assign fast_lat   = fast_q;
endmodule

// File: rtl/halt_lane.sv
module halt_lane #(
  parameter bit IS_RX = 1'b0
) (
  input  logic run,
  input  logic drain_full,
  input  logic fast_lat,
  input  logic dma_busy,
  input  logic wire_busy,
  input  logic fifo_empty,
  output logic may_pkt,
  output logic may_dma,
  output logic quiet
);
  logic drain_ok;

  // In-flight work must end; in full-drain mode the FIFO must also be empty.
  assign quiet    = !dma_busy && !wire_busy && (fast_lat || fifo_empty);
  // Step that moves the FIFO toward empty stays open during a full drain.
  assign drain_ok = drain_full && !fifo_empty;

  generate
    if (IS_RX) begin : g_rx
      assign may_pkt = run;
      assign may_dma = run || drain_ok;
    end else begin : g_tx
      assign may_pkt = run || drain_ok;
      assign may_dma = run;
    end
  endgenerate
endmodule

// File: rtl/orderly_halt.sv
module orderly_halt
  import halt_pkg::*;
#(
  parameter int NDIR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic            req_wdata,
  input  logic            fast_mode,
  input  logic [NDIR-1:0] dma_busy,
  input  logic [NDIR-1:0] wire_busy,
  input  logic [NDIR-1:0] fifo_empty,
  output logic [NDIR-1:0] may_pkt,
  output logic [NDIR-1:0] may_dma,
  output logic            susp_rd
);
  logic            run;
  logic            drain_full;
  logic            fast_lat;
  logic [NDIR-1:0] lane_quiet;

  halt_fsm #(.NDIR(NDIR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .fast_mode (fast_mode),
    .lane_quiet(lane_quiet),
    .run       (run),
    .drain_full(drain_full),
    .fast_lat  (fast_lat),
    .susp      (susp_rd)
  );

  for (genvar i = 0; i < NDIR; i++) begin : g_lane
    halt_lane #(.IS_RX(lane_is_rx(i))) u_lane (
      .run       (run),
      .drain_full(drain_full),
      .fast_lat  (fast_lat),
      .dma_busy  (dma_busy[i]),
      .wire_busy (wire_busy[i]),
      .fifo_empty(fifo_empty[i]),
      .may_pkt   (may_pkt[i]),
      .may_dma   (may_dma[i]),
      .quiet     (lane_quiet[i])
    );
  end
endmodule

// File: rtl/orderly_halt_chk.sv
module orderly_halt_chk #(
  parameter int NDIR = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_wr,
  input logic            req_wdata,
  input logic [NDIR-1:0] dma_busy,
  input logic [NDIR-1:0] wire_busy,
  input logic [NDIR-1:0] may_pkt,
  input logic [NDIR-1:0] may_dma,
  input logic            susp_rd
);
  // R2: a request cuts the feeding enables (tx DMA on lane 0, rx packets on lane 1)
  p_feed_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_wdata) |=> (!may_dma[0] && !may_pkt[1]));

  // R3: entry only follows a cycle with no in-flight work
  p_entry_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_rd) |-> (($past(dma_busy) == '0) && ($past(wire_busy) == '0)));

  // R5: suspended means every enable is closed
  p_gates_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    susp_rd |-> ((may_pkt == '0) && (may_dma == '0)));

  // R6: a write of 0 resumes in the next cycle
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !req_wdata) |=> (!susp_rd && (&may_pkt) && (&may_dma)));

  // R7: a repeated request while suspended changes nothing
  p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_rd && req_wr && req_wdata) |=> susp_rd);
endmodule

bind orderly_halt orderly_halt_chk #(.NDIR(NDIR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_wr   (req_wr),
  .req_wdata(req_wdata),
  .dma_busy (dma_busy),
  .wire_busy(wire_busy),
  .may_pkt  (may_pkt),
  .may_dma  (may_dma),
  .susp_rd  (susp_rd)
);

// File: tb/sim_orderly_halt.sv
`timescale 1ns/1ps
module sim_orderly_halt;
  localparam int NDIR = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_wr = 1'b0;
  logic            req_wdata = 1'b0;
  logic            fast_mode = 1'b0;
  logic [NDIR-1:0] dma_busy = '0;
  logic [NDIR-1:0] wire_busy = '0;
  logic [NDIR-1:0] fifo_empty = '1;
  logic [NDIR-1:0] may_pkt;
  logic [NDIR-1:0] may_dma;
  logic            susp_rd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic            susp;
    logic [NDIR-1:0] pkt;
    logic [NDIR-1:0] dma;
    string           tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  orderly_halt #(.NDIR(NDIR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
    .fast_mode(fast_mode), .dma_busy(dma_busy), .wire_busy(wire_busy),
    .fifo_empty(fifo_empty), .may_pkt(may_pkt), .may_dma(may_dma),
    .susp_rd(susp_rd)
  );

  // Monitor: compare outputs shortly after each edge with the queued expectation.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (susp_rd !== e.susp || may_pkt !== e.pkt || may_dma !== e.dma) begin
        failures++;
        $display("FAIL %s: got susp=%b pkt=%b dma=%b exp susp=%b pkt=%b dma=%b",
                 e.tag, susp_rd, may_pkt, may_dma, e.susp, e.pkt, e.dma);
      end
    end
  end

  // Driver: set inputs between edges, expect outputs after the next edge.
  task automatic step(input logic wr, input logic wd, input logic fm,
                      input logic [NDIR-1:0] db, input logic [NDIR-1:0] wb,
                      input logic [NDIR-1:0] fe, input logic es,
                      input logic [NDIR-1:0] ep, input logic [NDIR-1:0] ed,
                      input string tag);
    exp_t e;
    @(negedge clk);
    req_wr = wr; req_wdata = wd; fast_mode = fm;
    dma_busy = db; wire_busy = wb; fifo_empty = fe;
    e.susp = es; e.pkt = ep; e.dma = ed; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step(0,0,0, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R1 reset");
    // R9 clear while running
    step(1,0,0, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R9 clear in run");

    // Fast mode: tx DMA busy, rx on wire, FIFOs non-empty
    step(1,1,1, 2'b01,2'b10,2'b00, 0,2'b00,2'b00, "R2 fast gates off");
    step(0,0,1, 2'b01,2'b10,2'b00, 0,2'b00,2'b00, "R3 wait busy");
    step(0,0,1, 2'b00,2'b10,2'b00, 0,2'b00,2'b00, "R3 wait wire");
    step(0,0,1, 2'b00,2'b00,2'b00, 1,2'b00,2'b00, "R3 enter with data");
    step(0,0,0, 2'b00,2'b00,2'b00, 1,2'b00,2'b00, "R5 held");
    step(1,1,0, 2'b00,2'b00,2'b00, 1,2'b00,2'b00, "R7 rewrite in susp");
    step(1,0,0, 2'b00,2'b00,2'b00, 0,2'b11,2'b11, "R6 resume");

    // Full-drain mode: engines idle, both FIFOs hold data
    step(1,1,0, 2'b00,2'b00,2'b00, 0,2'b01,2'b10, "R4 drain enables");
    step(0,0,0, 2'b00,2'b00,2'b01, 0,2'b00,2'b10, "R4 tx empty rx not");
    step(0,0,1, 2'b00,2'b00,2'b01, 0,2'b00,2'b10, "R8 late fast ignored");
    step(0,0,0, 2'b00,2'b00,2'b11, 1,2'b00,2'b00, "R4 enter drained");
    step(1,0,0, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R6 resume full");

    // Cancel during drain
    step(1,1,1, 2'b01,2'b00,2'b11, 0,2'b00,2'b00, "R2 fast request");
    step(1,0,1, 2'b01,2'b00,2'b11, 0,2'b11,2'b11, "R6 cancel");
    step(0,0,1, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R6 no late entry");

    // Repeat request while draining does not re-sample mode
    step(1,1,1, 2'b01,2'b00,2'b00, 0,2'b00,2'b00, "R2 request fast");
    step(1,1,0, 2'b00,2'b00,2'b00, 1,2'b00,2'b00, "R7 rewrite in drain");
    step(1,0,0, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R6 resume again");

    // Immediate quiet: entry takes two edges
    step(1,1,1, 2'b00,2'b00,2'b11, 0,2'b00,2'b00, "R3 not same cycle");
    step(0,0,1, 2'b00,2'b00,2'b11, 1,2'b00,2'b00, "R3 next edge");
    step(1,0,1, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R6 final resume");
    step(0,0,0, 2'b00,2'b00,2'b11, 0,2'b11,2'b11, "R9 idle run");

    wait (sb.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule